// File: doc/BRIEF.md
# Configurable Interval and Watchdog Timer

This block is a down-counter that produces periodic timeouts and is controlled through a small word-addressed register port. Build-time parameters choose its variant. The period can be a host-programmable value or a fixed constant. A snapshot register can capture the live count so the host can read it. Start and halt control can be present, or the counter can run freely from reset. Two outputs are optional: a single-cycle tick strobe and a watchdog reset request.

The counter loads the period value and counts down to zero. A timeout happens on the cycle the running counter reaches zero. On a timeout the counter reloads the period. It then continues or stops, depending on a control bit. A sticky timeout flag records each event. The interrupt line is that flag gated by an enable bit.

In the watchdog variant the counter stays idle after reset until the host writes the go bit. This holds even when the start/stop option is off. Every timeout in this variant also pulses the reset request for one cycle.

Top module: `tmr_top`

## Requirements
- R1: After reset the status register (address 0) reads 0 in any variant with a go bit. The irq, tick_pulse and rst_req outputs are low. The period equals DEF_PERIOD.
- R2: With WR_PERIOD=1 the period has two halves: address 2 holds the low half and address 3 holds the high half. Writing either half loads the counter with the new period and, in a variant with a go bit, stops it. From a go, the first timeout comes period+1 cycles later.
- R3: With WR_PERIOD=0 the period is fixed at DEF_PERIOD and timeouts repeat every DEF_PERIOD+1 cycles. Reads of addresses 2 and 3 return 0, and writes to them have no effect.
- R4: With SNAP_EN=1 a write to address 4 or 5 captures the current count. Address 4 reads its low half and address 5 its high half. With SNAP_EN=0 both addresses read 0.
- R5: With STARTSTOP_EN=1, control register (address 1) bit 2 (go) starts the counter and bit 3 (halt) stops it. While halted the count is frozen and no timeouts occur.
- R6: When STARTSTOP_EN=0 and WDOG_EN=0, the counter runs from reset without stopping. Status bit 1 (running) reads 1, and writing the halt bit has no effect.
- R7: Control bit 1 (continue) selects what happens after a timeout reload: when set the counter keeps running, and when clear it stops and status bit 1 reads 0. This bit is ignored in the free-running variant.
- R8: Status bit 0 (timeout flag) is set by every timeout. Any write to address 0 clears it, and a timeout in the same cycle takes priority over the clear.
- R9: irq is high exactly when the timeout flag is set and control bit 0 (interrupt enable) is 1.
- R10: With PULSE_EN=1, tick_pulse is high for one cycle after each timeout, provided the period is non-zero.
- R11: With WDOG_EN=1 the counter is idle after reset until a go write, even when STARTSTOP_EN=0. Without that option, the halt bit is ignored. Each timeout pulses rst_req high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata valid the next cycle |
| addr | input | 3 | Register word address |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Registered read data |
| irq | output | 1 | Interrupt request (flag and enable) |
| tick_pulse | output | 1 | One-cycle strobe per timeout |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The period sweep from 1 to 8 checks that the go-to-timeout delay is exactly period+1 at every step, which separates a correct reload from an off-by-one count. One-shot runs are compared against continue-mode runs to confirm that the counter stops or re-arms as set. A snapshot taken while running is compared with one taken while halted, which shows both the capture instant and the frozen count. The fixed-period free-running instance and the watchdog instance receive halt and period writes, and their timeout spacing must stay unchanged.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] ADR_STAT    = 3'd0;
  localparam logic [2:0] ADR_CTRL    = 3'd1;
  localparam logic [2:0] ADR_PER_LO  = 3'd2;
  localparam logic [2:0] ADR_PER_HI  = 3'd3;
  localparam logic [2:0] ADR_SNAP_LO = 3'd4;
  localparam logic [2:0] ADR_SNAP_HI = 3'd5;

  localparam int C_IE   = 0;
  localparam int C_CONT = 1;
  localparam int C_GO   = 2;
  localparam int C_HALT = 3;

  typedef struct packed {
    logic cont;
    logic ie;
  } ctrl_t;
endpackage

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned DEF_PERIOD = 100,
  parameter bit          START_OK   = 1'b1,
  parameter bit          STOP_OK    = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period,
  input  logic             reload,
  input  logic             go,
  input  logic             halt,
  input  logic             cont,
  output logic [CNT_W-1:0] cnt,
  output logic             run,
  output logic             expire
);
  localparam bit FREE = !START_OK;

  assign expire = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CNT_W'(DEF_PERIOD);
      run <= FREE;
    end else begin
      if (reload) begin
        cnt <= period;
        if (!FREE) run <= 1'b0;
      end else if (expire) begin
        cnt <= period;
        if (!FREE && !cont) run <= 1'b0;
      end else if (run) begin
        cnt <= cnt - 1'b1;
      end
      if (START_OK && go)  run <= 1'b1;
      if (STOP_OK && halt) run <= 1'b0;
    end
  end

  // R2: a period write lands in the counter on the next cycle
  a_r2_reload_value: assert property (@(posedge clk) disable iff (rst)
    reload |=> cnt == $past(period));

  generate
    if (START_OK) begin : g_startable
      // R11 / R5: the counter only begins running because of a go write
      a_r11_start_needs_go: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> $past(go));
    end else begin : g_free
      // R6: free-running variant never stops
      a_r6_free_runs: assert property (@(posedge clk) disable iff (rst) run);
    end
  endgenerate
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned BUS_W      = 16,
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned DEF_PERIOD = 100,
  parameter bit          WR_PERIOD  = 1'b1,
  parameter bit          SNAP_EN    = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             run,
  input  logic             tmo,
  output logic [CNT_W-1:0] period_nxt,
  output logic             reload,
  output logic             go,
  output logic             halt,
  output logic             clr_tmo,
  output logic             ie,
  output logic             cont,
  output logic [BUS_W-1:0] rdata
);
  localparam int unsigned HI_LSB = BUS_W;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] per_rd;
  logic [CNT_W-1:0] snap_rd;

  logic wr_stat, wr_ctrl, wr_plo, wr_phi, wr_snap;
  assign wr_stat = wr_en && (addr == ADR_STAT);
  assign wr_ctrl = wr_en && (addr == ADR_CTRL);
  assign wr_plo  = wr_en && (addr == ADR_PER_LO);
  assign wr_phi  = wr_en && (addr == ADR_PER_HI);
  assign wr_snap = wr_en && ((addr == ADR_SNAP_LO) || (addr == ADR_SNAP_HI));

  assign go      = wr_ctrl && wdata[C_GO];
  assign halt    = wr_ctrl && wdata[C_HALT];
  assign clr_tmo = wr_stat;
  assign ie      = ctrl_q.ie;
  assign cont    = ctrl_q.cont;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_ctrl) begin
      ctrl_q.ie   <= wdata[C_IE];
      ctrl_q.cont <= wdata[C_CONT];
    end
  end

  generate
    if (WR_PERIOD) begin : g_per
      logic [CNT_W-1:0] per_q;
      always_comb begin
        period_nxt = per_q;
        if (wr_plo) period_nxt[HI_LSB-1:0]     = wdata;
        if (wr_phi) period_nxt[CNT_W-1:HI_LSB] = wdata;
      end
      always_ff @(posedge clk) begin
        if (rst) per_q <= CNT_W'(DEF_PERIOD);
        else     per_q <= period_nxt;
      end
      assign reload = wr_plo || wr_phi;
      assign per_rd = per_q;
    end else begin : g_fixed
      assign period_nxt = CNT_W'(DEF_PERIOD);
      assign reload     = 1'b0;
      assign per_rd     = '0;
    end

    if (SNAP_EN) begin : g_snap
      logic [CNT_W-1:0] snap_q;
      always_ff @(posedge clk) begin
        if (rst)          snap_q <= '0;
        else if (wr_snap) snap_q <= cnt;
      end
      assign snap_rd = snap_q;
    end else begin : g_nosnap
      assign snap_rd = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        ADR_STAT:    rdata <= BUS_W'({run, tmo});
        ADR_CTRL:    rdata <= BUS_W'(ctrl_q);
        ADR_PER_LO:  rdata <= per_rd[HI_LSB-1:0];
        ADR_PER_HI:  rdata <= per_rd[CNT_W-1:HI_LSB];
        ADR_SNAP_LO: rdata <= snap_rd[HI_LSB-1:0];
        ADR_SNAP_HI: rdata <= snap_rd[CNT_W-1:HI_LSB];
        default:     rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_events.sv
module tmr_events #(
  parameter bit PULSE_EN = 1'b1,
  parameter bit WDOG_EN  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic clr,
  input  logic ie,
  output logic tmo,
  output logic irq,
  output logic tick_pulse,
  output logic rst_req
);
  always_ff @(posedge clk) begin
    if (rst)         tmo <= 1'b0;
    else if (expire) tmo <= 1'b1;
    else if (clr)    tmo <= 1'b0;
  end

  assign irq = tmo && ie;

  generate
    if (PULSE_EN) begin : g_pulse
      always_ff @(posedge clk) begin
        if (rst) tick_pulse <= 1'b0;
        else     tick_pulse <= expire;
      end
    end else begin : g_nopulse
      assign tick_pulse = 1'b0;
    end

    if (WDOG_EN) begin : g_wdog
      always_ff @(posedge clk) begin
        if (rst) rst_req <= 1'b0;
        else     rst_req <= expire;
      end
    end else begin : g_nowdog
      assign rst_req = 1'b0;
    end
  endgenerate

  // R8: the flag only rises because the counter expired
  a_r8_flag_source: assert property (@(posedge clk) disable iff (rst)
    $rose(tmo) |-> $past(expire));
endmodule

// File: rtl/tmr_top.sv
module tmr_top #(
  parameter int unsigned BUS_W        = 16,
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned DEF_PERIOD   = 100,
  parameter bit          WR_PERIOD    = 1'b1,
  parameter bit          SNAP_EN      = 1'b1,
  parameter bit          STARTSTOP_EN = 1'b1,
  parameter bit          PULSE_EN     = 1'b1,
  parameter bit          WDOG_EN      = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  output logic             irq,
  output logic             tick_pulse,
  output logic             rst_req
);
  localparam bit START_OK = STARTSTOP_EN || WDOG_EN;

  logic [CNT_W-1:0] cnt, period_nxt;
  logic run, expire, reload, go, halt, cont, clr_tmo, ie, tmo;

  tmr_regs #(
    .BUS_W(BUS_W), .CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD),
    .WR_PERIOD(WR_PERIOD), .SNAP_EN(SNAP_EN)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt(cnt), .run(run), .tmo(tmo),
    .period_nxt(period_nxt), .reload(reload), .go(go), .halt(halt),
    .clr_tmo(clr_tmo), .ie(ie), .cont(cont), .rdata(rdata)
  );

  tmr_core #(
    .CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD),
    .START_OK(START_OK), .STOP_OK(STARTSTOP_EN)
  ) u_core (
    .clk(clk), .rst(rst), .period(period_nxt), .reload(reload),
    .go(go), .halt(halt), .cont(cont),
    .cnt(cnt), .run(run), .expire(expire)
  );

  tmr_events #(.PULSE_EN(PULSE_EN), .WDOG_EN(WDOG_EN)) u_evt (
    .clk(clk), .rst(rst), .expire(expire), .clr(clr_tmo), .ie(ie),
    .tmo(tmo), .irq(irq), .tick_pulse(tick_pulse), .rst_req(rst_req)
  );

  // R10: with a non-zero period the strobe never lasts two cycles
  a_r10_pulse_single: assert property (@(posedge clk) disable iff (rst)
    tick_pulse && ($past(period_nxt) != '0) |=> !tick_pulse);

  generate
    if (WDOG_EN) begin : g_wd_chk
      // R11: reset request follows a counter that was running at zero
      a_r11_req_source: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(run && (cnt == '0)));
    end
  endgenerate
endmodule

// File: tb/tmr_top_tb.sv
module tmr_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [2:0]  wr_v = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata_f, rdata_p, rdata_w;
  logic irq_f, irq_p, irq_w;
  logic pulse_f, pulse_p, pulse_w;
  logic rreq_f, rreq_p, rreq_w;

  int checks = 0;
  int fails  = 0;

  // Full-featured: programmable period, snapshot, start/stop
  tmr_top #(.DEF_PERIOD(100), .WR_PERIOD(1), .SNAP_EN(1), .STARTSTOP_EN(1),
            .PULSE_EN(1), .WDOG_EN(0)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_v[0]), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_f), .irq(irq_f), .tick_pulse(pulse_f),
    .rst_req(rreq_f));

  // Simple periodic: fixed period 4, free-running
  tmr_top #(.DEF_PERIOD(4), .WR_PERIOD(0), .SNAP_EN(0), .STARTSTOP_EN(0),
            .PULSE_EN(1), .WDOG_EN(0)) u_per (
    .clk(clk), .rst(rst), .wr_en(wr_v[1]), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_p), .irq(irq_p), .tick_pulse(pulse_p),
    .rst_req(rreq_p));

  // Watchdog: fixed period 9, no start/stop option
  tmr_top #(.DEF_PERIOD(9), .WR_PERIOD(0), .SNAP_EN(1), .STARTSTOP_EN(0),
            .PULSE_EN(1), .WDOG_EN(1)) u_wd (
    .clk(clk), .rst(rst), .wr_en(wr_v[2]), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata_w), .irq(irq_w), .tick_pulse(pulse_w),
    .rst_req(rreq_w));

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int d, input logic [2:0] a, input logic [15:0] v);
    @(negedge clk);
    addr = a; wdata = v; wr_v = '0; wr_v[d] = 1'b1;
    @(posedge clk); #1;
    wr_v = '0;
  endtask

  task automatic rd(input int d, input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
    v = (d == 0) ? rdata_f : (d == 1) ? rdata_p : rdata_w;
  endtask

  function automatic logic evt(input int d);
    return (d == 0) ? pulse_f : (d == 1) ? pulse_p : rreq_w;
  endfunction

  task automatic wait_evt(input int d, output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!evt(d) && n < 1000);
  endtask

  task automatic count_evt(input int d, input int cyc, output int c);
    c = 0;
    repeat (cyc) begin
      @(posedge clk); #1;
      if (evt(d)) c++;
    end
  endtask

  task automatic run_all();
    logic [15:0] v, a0, b0;
    int n, c;
    // ---- reset state
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    check("R1 irq low", irq_f, 0);
    check("R1 pulse low", pulse_f, 0);
    check("R1 rst_req low", rreq_w, 0);
    rd(0, 3'd0, v); check("R1 status", v, 0);
    rd(0, 3'd2, v); check("R1 default period", v, 100);
    rd(2, 3'd0, v); check("R1 wd status", v, 0);
    count_evt(0, 150, c); check("R5 idle without go", c, 0);

    // ---- periodic instance
    rd(1, 3'd2, v); check("R3 period reads zero", v, 0);
    wait_evt(1, n);
    wait_evt(1, n); check("R3 fixed interval", n, 5);
    check("R9 irq masked", irq_p, 0);
    rd(1, 3'd0, v); check("R6 R8 status run+flag", v, 3);
    wr(1, 3'd1, 16'h0001); check("R9 irq enabled", irq_p, 1);
    wait_evt(1, n);
    wr(1, 3'd0, 16'h0000); check("R8 flag clear irq", irq_p, 0);
    rd(1, 3'd0, v); check("R8 flag cleared", v, 2);
    wait_evt(1, n);
    wr(1, 3'd1, 16'h0008);
    wait_evt(1, n);
    wait_evt(1, n); check("R6 halt ignored", n, 5);
    wr(1, 3'd2, 16'h0001);
    wait_evt(1, n);
    wait_evt(1, n); check("R3 period write ignored", n, 5);
    rd(1, 3'd4, v); check("R4 snapshot absent", v, 0);

    // ---- full-featured: period sweep, one-shot
    for (int p = 1; p <= 8; p++) begin
      wr(0, 3'd2, 16'(p));
      wr(0, 3'd3, 16'h0000);
      wr(0, 3'd1, 16'h0005);
      wait_evt(0, n); check($sformatf("R2 R5 go-to-timeout p=%0d", p), n, p + 1);
      check("R9 irq on timeout", irq_f, 1);
      @(posedge clk); #1; check("R10 pulse one cycle", pulse_f, 0);
      rd(0, 3'd0, v); check("R7 one-shot stopped", v, 1);
      wr(0, 3'd0, 16'h0000);
    end
    // continue mode
    wr(0, 3'd2, 16'd3);
    wr(0, 3'd1, 16'h0006);
    for (int k = 0; k < 3; k++) begin
      wait_evt(0, n); check("R7 continue interval", n, 4);
    end
    wr(0, 3'd1, 16'h0008);
    count_evt(0, 20, c); check("R5 halt stops timeouts", c, 0);
    rd(0, 3'd0, v); check("R5 running bit cleared", (v >> 1) & 1, 0);
    // snapshot while running
    wr(0, 3'd2, 16'd20);
    wr(0, 3'd1, 16'h0004);
    repeat (5) @(posedge clk);
    wr(0, 3'd4, 16'h0000);
    rd(0, 3'd4, v); check("R4 snapshot low", v, 15);
    rd(0, 3'd5, v); check("R4 snapshot high", v, 0);
    // halted count frozen
    wr(0, 3'd1, 16'h0008);
    wr(0, 3'd5, 16'h0000);
    rd(0, 3'd4, a0);
    repeat (10) @(posedge clk);
    wr(0, 3'd4, 16'h0000);
    rd(0, 3'd4, b0);
    check("R5 frozen while halted", b0, a0);
    // high half of period
    wr(0, 3'd3, 16'h0001);
    wr(0, 3'd4, 16'h0000);
    rd(0, 3'd5, v); check("R2 high half reload", v, 1);
    rd(0, 3'd4, v); check("R2 low half kept", v, 20);
    rd(0, 3'd0, v); check("R2 period write stops", (v >> 1) & 1, 0);

    // ---- watchdog instance
    count_evt(2, 40, c); check("R11 idle after reset", c, 0);
    wr(2, 3'd1, 16'h0004);
    wait_evt(2, n); check("R11 go-to-request", n, 10);
    @(posedge clk); #1; check("R11 request one cycle", rreq_w, 0);
    count_evt(2, 40, c); check("R7 watchdog one-shot", c, 0);
    wr(2, 3'd1, 16'h0004);
    wr(2, 3'd1, 16'h0008);
    wait_evt(2, n); check("R11 halt ignored", n, 9);
  endtask

  initial begin
    fork
      run_all();
      begin
        #1ms;
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule